// File: doc/BRIEF.md
# Threshold-Gated Interrupt Priority Arbiter

This block selects one interrupt source out of a set of contenders and decides whether that source deserves the host's attention. Contenders are grouped by channel: each channel has a fixed number of source types, which is eight channels of three types by default. Every contender supplies a bid value, an active flag and an enable bit. The bid values are data, not fixed positions. They normally encode how urgent the source currently is, for example how full a receive buffer has become.

Work happens in fixed-length rounds of `ROUND_LEN` clocks. On the first clock of a round the block looks at all contenders and finds the best qualifying bid. A bid qualifies when its upper bits are strictly greater than a programmable threshold. That result is held until the last clock of the round and then published. The active-low request output follows the published winner. When an acknowledge falls, or when software issues an update command, the published winner is frozen into a snapshot word. Software then decodes the channel, the source type and the bid from that word. A snapshot of zero means that nothing was pending.

Top module: `irq_thresh_arbiter`

## Requirements
- R1: While reset is applied, and after it until the first round has been published, `irq_n` is 1 and `cir` is 0.
- R2: A contender is eligible only when its active and enable bits are both 1 and its bid bits [9:3] (the top `THR_W` bits), read as an unsigned number, are strictly greater than `threshold`. Bid bits [2:0] play no part in this test.
- R3: Among the eligible contenders, the one with the largest 10-bit bid wins.
- R4: Contender index i belongs to channel i/3 and has type code (i mod 3)+1. When bids are equal, the higher channel code wins. When the channel is also the same, the higher type code wins.
- R5: Rounds are 22 clocks long. Inputs are sampled on the first rising edge after reset and on every 22nd edge after that. The winner is published on the 22nd edge of the round. An input change made after the sampling edge shows up only in the next round.
- R6: `irq_n` is 0 exactly when the published winner exists and that contender's enable bit is 1 at present. `irq_n` otherwise changes only at a publishing edge.
- R7: A falling edge on `iack_n`, or a clock with `update_cmd` at 1, loads `cir` with {channel[14:12], type[11:10], bid[9:0]} of the published winner.
- R8: If there is no published winner at capture time, or the winner's enable bit has since been cleared, the capture loads 0.
- R9: `cir` holds its value until the next capture event. Keeping `iack_n` low does not trigger another capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| src_bid | input | NSRC*BID_W (240) | Bid of contender i at bits [i*10 +: 10] |
| src_active | input | NSRC (24) | Contender is presenting a bid |
| src_enable | input | NSRC (24) | Mask enable for each contender |
| threshold | input | THR_W (7) | Compared against bid bits [9:3] |
| iack_n | input | 1 | Interrupt acknowledge, active low; the falling edge captures |
| update_cmd | input | 1 | Single-clock software capture command |
| irq_n | output | 1 | Interrupt request, active low |
| cir | output | CIR_W (15) | Captured winner: channel, type, bid |

## Verification
Two situations are hard to reach from the ports. The first is an input change that lands inside a round, after the sampling edge but before publication. The second is a winner whose enable is removed between publication and capture. The bench counts clock edges from the release of reset, so it always knows where a round starts. It changes inputs at chosen edge offsets and checks `irq_n` one edge before and one edge after publication. It clears the winner's enable after publication and then issues a capture. A full sweep of the threshold, with pseudo-random bids and masks, exercises the strict-greater boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Strict unsigned compare of the bid's upper field against the threshold.
  function automatic logic above_threshold(input int unsigned bid_top, input int unsigned thr);
    return bid_top > thr;
  endfunction

  // A later contender replaces the held one on an equal or larger bid.
  // Later index means a higher channel, or the same channel with a higher type.
  function automatic logic takes_over(input logic have, input int unsigned cand, input int unsigned held);
    return !have || (cand >= held);
  endfunction

  function automatic int chan_of(input int idx, input int ntype);
    return idx / ntype;
  endfunction

  // Type codes start at 1, so a valid capture is never all zeros.
  function automatic int type_of(input int idx, input int ntype);
    return (idx % ntype) + 1;
  endfunction

endpackage

// File: rtl/irq_round_timer.sv
module irq_round_timer #(
  parameter int ROUND_LEN = 22,
  localparam int CNT_W = $clog2(ROUND_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_evt,
  output logic publish_evt
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (publish_evt) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign sample_evt  = (cnt == '0);
  assign publish_evt = (cnt == CNT_W'(ROUND_LEN - 1));
endmodule

// File: rtl/irq_eligibility.sv
module irq_eligibility import irq_arb_pkg::*; #(
  parameter int NSRC  = 24,
  parameter int THR_W = 7
) (
  input  logic [NSRC*THR_W-1:0] bid_top,
  input  logic [NSRC-1:0]       src_active,
  input  logic [NSRC-1:0]       src_enable,
  input  logic [THR_W-1:0]      threshold,
  output logic [NSRC-1:0]       eligible
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [THR_W-1:0] top_g;
    assign top_g = bid_top[g*THR_W +: THR_W];
    assign eligible[g] = src_active[g] & src_enable[g]
                       & above_threshold(32'(top_g), 32'(threshold));
  end
endmodule

// File: rtl/irq_winner_select.sv
module irq_winner_select import irq_arb_pkg::*; #(
  parameter int NSRC  = 24,
  parameter int BID_W = 10,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC*BID_W-1:0] src_bid,
  input  logic [NSRC-1:0]       eligible,
  output logic                  best_valid,
  output logic [IDX_W-1:0]      best_idx,
  output logic [BID_W-1:0]      best_bid
);
  always_comb begin
    best_valid = 1'b0;
    best_idx   = '0;
    best_bid   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && takes_over(best_valid, 32'(src_bid[i*BID_W +: BID_W]), 32'(best_bid))) begin
        best_valid = 1'b1;
        best_idx   = IDX_W'(i);
        best_bid   = src_bid[i*BID_W +: BID_W];
      end
    end
  end
endmodule

// File: rtl/irq_thresh_arbiter.sv
module irq_thresh_arbiter import irq_arb_pkg::*; #(
  parameter int NUM_CHAN  = 8,
  parameter int NUM_TYPE  = 3,
  parameter int BID_W     = 10,
  parameter int THR_W     = 7,
  parameter int ROUND_LEN = 22,
  localparam int NSRC  = NUM_CHAN * NUM_TYPE,
  localparam int CH_W  = $clog2(NUM_CHAN),
  localparam int TY_W  = $clog2(NUM_TYPE + 1),
  localparam int CIR_W = CH_W + TY_W + BID_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC*BID_W-1:0] src_bid,
  input  logic [NSRC-1:0]       src_active,
  input  logic [NSRC-1:0]       src_enable,
  input  logic [THR_W-1:0]      threshold,
  input  logic                  iack_n,
  input  logic                  update_cmd,
  output logic                  irq_n,
  output logic [CIR_W-1:0]      cir
);
  localparam int IDX_W = $clog2(NSRC);

  // Upper bid fields, collected for the threshold compare.
  logic [NSRC*THR_W-1:0] bid_top;
  for (genvar g = 0; g < NSRC; g++) begin : g_top
    assign bid_top[g*THR_W +: THR_W] = src_bid[g*BID_W + BID_W - THR_W +: THR_W];
  end

  logic [NSRC-1:0]  eligible;
  logic             best_valid;
  logic [IDX_W-1:0] best_idx;
  logic [BID_W-1:0] best_bid;
  logic             sample_evt, publish_evt;

  irq_round_timer #(.ROUND_LEN(ROUND_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .publish_evt(publish_evt)
  );

  irq_eligibility #(.NSRC(NSRC), .THR_W(THR_W)) u_elig (
    .bid_top(bid_top), .src_active(src_active), .src_enable(src_enable),
    .threshold(threshold), .eligible(eligible)
  );

  irq_winner_select #(.NSRC(NSRC), .BID_W(BID_W)) u_sel (
    .src_bid(src_bid), .eligible(eligible),
    .best_valid(best_valid), .best_idx(best_idx), .best_bid(best_bid)
  );

  // Result taken at the opening edge, held until the closing edge.
  logic             pend_valid, win_valid;
  logic [IDX_W-1:0] pend_idx, win_idx;
  logic [BID_W-1:0] pend_bid, win_bid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0; pend_idx <= '0; pend_bid <= '0;
      win_valid  <= 1'b0; win_idx  <= '0; win_bid  <= '0;
    end else begin
      if (sample_evt) begin
        pend_valid <= best_valid; pend_idx <= best_idx; pend_bid <= best_bid;
      end
      if (publish_evt) begin
        win_valid <= pend_valid; win_idx <= pend_idx; win_bid <= pend_bid;
      end
    end
  end

  // A winner whose mask bit was cleared since publication no longer counts.
  logic win_live;
  assign win_live = win_valid & src_enable[win_idx];
  assign irq_n    = ~win_live;

  logic iack_q, iack_fall, cap_evt;
  assign iack_fall = iack_q & ~iack_n;
  assign cap_evt   = iack_fall | update_cmd;

  logic [CH_W-1:0] win_chan;
  logic [TY_W-1:0] win_type;
  assign win_chan = CH_W'(chan_of(int'(win_idx), NUM_TYPE));
  assign win_type = TY_W'(type_of(int'(win_idx), NUM_TYPE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q <= 1'b1;
      cir    <= '0;
    end else begin
      iack_q <= iack_n;
      if (cap_evt) cir <= win_live ? {win_chan, win_type, win_bid} : '0;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int ROUND_LEN = 22,
  parameter int CIR_W     = 15,
  parameter int NSRC      = 24,
  localparam int GW = $clog2(ROUND_LEN) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic [CIR_W-1:0] cir,
  input logic [NSRC-1:0]  src_enable,
  input logic             cap_evt,
  input logic             publish_evt
);
  logic [GW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (publish_evt) gap <= '0;
    else gap <= gap + 1'b1;
  end

  // R5
  round_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    publish_evt |-> gap == GW'(ROUND_LEN - 1));

  // R6
  irq_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_n) |-> ($past(publish_evt) || !$stable(src_enable)));

  // R7
  cir_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !irq_n) |=> cir != '0);

  // R8
  cir_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && irq_n) |=> cir == '0);

  // R9
  cir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cir));
endmodule

bind irq_thresh_arbiter irq_arb_chk #(.ROUND_LEN(ROUND_LEN), .CIR_W(CIR_W), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cir(cir), .src_enable(src_enable),
  .cap_evt(cap_evt), .publish_evt(publish_evt)
);

// File: tb/test_irq_thresh_arbiter.sv
`timescale 1ns/1ps
module test_irq_thresh_arbiter;
  localparam int NS = 24, BW = 10, TW = 7, RL = 22, CW = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [BW-1:0] bids [NS];
  logic [NS-1:0] act = '0, en = '0;
  logic [TW-1:0] thr = '0;
  logic iack_n = 1'b1, upd = 1'b0;
  logic irq_n;
  logic [CW-1:0] cir;
  logic [NS*BW-1:0] bid_flat;

  always_comb
    for (int i = 0; i < NS; i++) bid_flat[i*BW +: BW] = bids[i];

  irq_thresh_arbiter i_irq_thresh_arbiter (
    .clk(clk), .rst_n(rst_n), .src_bid(bid_flat), .src_active(act), .src_enable(en),
    .threshold(thr), .iack_n(iack_n), .update_cmd(upd), .irq_n(irq_n), .cir(cir)
  );

  int checks = 0, fails = 0, ecount = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h2545_F491;

  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // Score ranks bid first, then channel, then type; the packed word is built from the winner.
  function automatic logic [CW-1:0] model_cir();
    int best_i = -1;
    int best_s = -1;
    for (int i = 0; i < NS; i++) begin
      if (act[i] && en[i] && (int'(bids[i] >> 3) > int'(thr))) begin
        int s = int'(bids[i]) * 32 + (i / 3) * 4 + (i % 3) + 1;
        if (s > best_s) begin best_s = s; best_i = i; end
      end
    end
    if (best_i < 0) return '0;
    return CW'(((best_i / 3) << 12) + (((best_i % 3) + 1) << 10) + int'(bids[best_i]));
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < NS; i++) bids[i] = '0;
    act = '0; en = '0;
  endtask

  task automatic wait_sample();
    @(negedge clk);
    while (ecount % RL != 0) @(negedge clk);
  endtask

  task automatic run_round();
    wait_sample();
    repeat (RL) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_update();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic round_and_check(input string tag);
    logic [CW-1:0] e;
    e = model_cir();
    run_round();
    check({tag, " irq"}, int'(irq_n), (e != 0) ? 0 : 1);
    do_update();
    check({tag, " cir"}, int'(cir), int'(e));
  endtask

  initial begin
    logic [CW-1:0] ea;
    clear_all();
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 reset irq", int'(irq_n), 1);
    check("R1 reset cir", int'(cir), 0);
    rst_n = 1'b1;
    act = '1; en = '1; thr = '0;
    for (int i = 0; i < NS; i++) bids[i] = 10'h3FF;
    repeat (10) @(negedge clk);
    check("R1 before first publish irq", int'(irq_n), 1);
    check("R1 before first publish cir", int'(cir), 0);

    // R4: everything equal -> channel 7, type 3
    for (int i = 0; i < NS; i++) bids[i] = 10'h155;
    round_and_check("R4 all equal");
    check("R4 all equal literal", int'(cir), int'({3'd7, 2'd3, 10'h155}));

    // R4: channel tie only
    clear_all();
    bids[4] = 10'h2A0; bids[16] = 10'h2A0; act[4] = 1; act[16] = 1; en = '1;
    round_and_check("R4 channel tie");
    check("R4 channel tie literal", int'(cir), int'({3'd5, 2'd2, 10'h2A0}));

    // R4: same channel, type decides
    clear_all();
    en = '1;
    for (int i = 12; i < 15; i++) begin bids[i] = 10'h0F8; act[i] = 1; end
    round_and_check("R4 type tie");
    check("R4 type tie literal", int'(cir), int'({3'd4, 2'd3, 10'h0F8}));

    // R3: larger bid beats a higher channel
    clear_all();
    en = '1; bids[1] = 10'h300; bids[22] = 10'h2FF; act[1] = 1; act[22] = 1;
    round_and_check("R3 bid over channel");
    check("R3 bid over channel literal", int'(cir), int'({3'd0, 2'd2, 10'h300}));

    // R2: equal upper field does not qualify; low bits ignored
    clear_all();
    en = '1; thr = 7'h40; act[7] = 1; bids[7] = {7'h40, 3'b111};
    round_and_check("R2 equal to threshold");
    check("R2 equal to threshold irq", int'(irq_n), 1);
    bids[7] = {7'h41, 3'b000};
    round_and_check("R2 one above threshold");
    thr = 7'h7F; bids[7] = 10'h3FF;
    round_and_check("R2 maximum threshold");

    // R2: a masked source with the top bid is skipped
    clear_all();
    thr = '0; act = '1; en = '1;
    for (int i = 0; i < NS; i++) bids[i] = 10'h010;
    bids[19] = 10'h3F0; en[19] = 1'b0;
    round_and_check("R2 masked top bid");

    // R6 and R8: enable cleared after publication
    clear_all();
    thr = '0; act[5] = 1; en[5] = 1; bids[5] = 10'h1C0;
    run_round();
    check("R6 winner published", int'(irq_n), 0);
    en[5] = 1'b0;
    #1;
    check("R6 enable cleared irq", int'(irq_n), 1);
    do_update();
    check("R8 capture after unmask", int'(cir), 0);

    // R5: mid-round change is deferred to the next round
    clear_all();
    en = '1;
    round_and_check("R5 idle baseline");
    act[10] = 1; bids[10] = 10'h200;
    ea = model_cir();
    wait_sample();
    repeat (5) @(posedge clk);
    act[10] = 0; act[20] = 1; bids[20] = 10'h300;
    repeat (RL - 6) @(posedge clk);
    @(negedge clk);
    check("R5 before publish edge", int'(irq_n), 1);
    @(posedge clk);
    @(negedge clk);
    check("R5 after publish edge", int'(irq_n), 0);
    do_update();
    check("R5 sampled value captured", int'(cir), int'(ea));
    round_and_check("R5 next round");

    // R7 and R9: acknowledge edge, held low, released and pulsed again
    iack_n = 1'b0;
    @(negedge clk);
    check("R7 iack capture", int'(cir), int'(model_cir()));
    ea = model_cir();
    act[20] = 0; act[2] = 1; bids[2] = 10'h3C0;
    run_round();
    check("R9 held iack new irq", int'(irq_n), 0);
    repeat (3) @(negedge clk);
    check("R9 held iack no recapture", int'(cir), int'(ea));
    iack_n = 1'b1;
    @(negedge clk);
    check("R9 release holds", int'(cir), int'(ea));
    iack_n = 1'b0;
    @(negedge clk);
    check("R7 second iack capture", int'(cir), int'({3'd0, 2'd3, 10'h3C0}));
    iack_n = 1'b1;

    // R2 R3 R4 R6 R7 R8: full threshold sweep with pseudo-random contenders
    for (int t = 0; t < 128; t++) begin
      thr = TW'(t);
      for (int i = 0; i < NS; i++) bids[i] = BW'(rnd());
      act = NS'(rnd()) | NS'(rnd());
      en  = NS'(rnd()) | NS'(rnd());
      if (t % 16 == 5) act = '0;
      round_and_check("R3 sweep");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule